// File: doc/BRIEF.md
# Permission-Checked Bus Address Decoder

This block sits between a CPU's memory port and a small set of peripheral regions. Each cycle it takes at most one request: a load, a store, an instruction fetch or a bulk-load write. It finds the region the address belongs to and checks that region's permission bits. If the access is allowed, it passes the request on with a region-relative offset, byte enables and lane-replicated store data. Read data from the selected region comes back on a 32-bit big-endian path, narrowed to the requested byte or halfword.

Every region is set by parameters: a base address, a mask, and four permission bits. The permission bits are read, write, execute and bulk-load. The decoder itself is purely combinational.

A request that hits no region, or that lacks the permission it needs, never reaches a device. Such a request also sets a sticky error flag. The CPU reads the flag with a sample strobe, and that strobe clears the flag.

Top module: `perm_bus_decoder`

## Requirements
- R1: A region matches when `(req_addr & mask) == base`. When several regions match, the lowest-indexed one is selected. `dev_sel` is one-hot with bit i standing for region i, and is all zero for any request that is not granted.
- R2: `dev_offset` equals `req_addr & ~mask` of the selected region. Bits 1:0 are cleared for word-sized accesses (size code 2 or 3, every fetch and every bulk-load), and bit 0 is cleared for halfword accesses (size code 1). Size code 0 is a byte.
- R3: A load (kind code 0) needs the read permission (perm bit 3). A load that hits no region, or a region without read permission, returns zero on `rsp_rdata` and selects no device.
- R4: A store (kind code 1) needs the write permission (perm bit 2). Without it, `dev_we`, `dev_sel` and `dev_be` stay zero.
- R5: An instruction fetch (kind code 2) needs the execute permission (perm bit 1). It always returns the full word whatever the size code. Without execute permission it returns zero.
- R6: A bulk-load (kind code 3) needs the load permission (perm bit 0). It writes a full word with all four byte enables set, even to a region that has no write permission.
- R7: Read data is big-endian. A byte load returns bits `8*(3-addr[1:0])+7` down to `8*(3-addr[1:0])` of the selected region's word. A halfword load returns bits 31:16 when addr[1]=0 and bits 15:0 when addr[1]=1. A word load returns the whole word.
- R8: For a granted store, a byte is repeated into all four lanes and a halfword into both halves. `dev_be` enables only the addressed lanes, with bit 3 standing for data bits 31:24.
- R9: Any valid request that is not granted sets `err_flag` from the next cycle on. The flag holds until a cycle with `err_sample` high. It then reads low from the following cycle, unless a new refused request arrives in that same cycle, in which case it stays set.
- R10: Reset clears `err_flag`.
- R11: With `req_valid` low, no device is selected, nothing is written and the error flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 bulk-load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| err_sample | input | 1 | CPU reads the error flag; clears it |
| dev_sel | output | NREG | One-hot region select |
| dev_offset | output | AW | Region-relative aligned offset |
| dev_we | output | 1 | Write strobe to the selected region |
| dev_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| dev_wdata | output | 32 | Lane-replicated write data |
| dev_rdata | input | NREG*32 | Read words, region i in bits 32*i+31:32*i |
| rsp_rdata | output | 32 | Narrowed read data to the CPU |
| err_flag | output | 1 | Sticky bus-error flag |

## Verification
The select, offset, enables, write data and read data are all combinational, so each is due in the same cycle as the request. The error flag is registered and shows the effect of a request one cycle later. The bench drives each request just after a rising edge and queues the expected outputs. A monitor compares those outputs at the following falling edge, taking the expected flag value from the model state left by the previous requests. Because of this, a refused request is seen on `err_flag` in the item queued for the next cycle, and a sample strobe is seen clearing the flag there as well.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BULK  = 2'd3
  } acc_kind_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } acc_size_t;

  // permission bit positions within a region's 4-bit field
  localparam int PB_READ  = 3;
  localparam int PB_WRITE = 2;
  localparam int PB_EXEC  = 1;
  localparam int PB_BULK  = 0;
endpackage

// File: rtl/pbd_region_match.sv
module pbd_region_match #(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter logic [NREG*AW-1:0] REG_BASE = '0,
  parameter logic [NREG*AW-1:0] REG_MASK = '0,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [NREG-1:0] sel_oh,
  output logic [IW-1:0]   sel_idx
);
  logic [NREG-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_cmp
      assign hit_vec[g] = ((addr & REG_MASK[g*AW +: AW]) == REG_BASE[g*AW +: AW]);
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    sel_oh  = '0;
    sel_idx = '0;
    hit     = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        sel_idx   = IW'(i);
        hit       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbd_lane_steer.sv
module pbd_lane_steer
  import pbd_pkg::*;
(
  input  logic [1:0]        size,
  input  logic              whole,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rword,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wrep,
  output logic [DATA_W-1:0] rnarrow
);
  acc_size_t sz;

  always_comb begin
    sz = whole ? SZ_WORD : acc_size_t'(size);
    case (sz)
      SZ_BYTE: begin
        be      = 4'b1000 >> lo;
        wrep    = {LANES{wdata[7:0]}};
        rnarrow = {24'd0, rword[8*(3-lo) +: 8]};
      end
      SZ_HALF: begin
        be      = lo[1] ? 4'b0011 : 4'b1100;
        wrep    = {2{wdata[15:0]}};
        rnarrow = {16'd0, (lo[1] ? rword[15:0] : rword[31:16])};
      end
      default: begin
        be      = '1;
        wrep    = wdata;
        rnarrow = rword;
      end
    endcase
  end
endmodule

// File: rtl/pbd_err_flag.sv
module pbd_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic sample,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = fault | sample;
    flag_d  = fault;   // a new fault wins over the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/perm_bus_decoder.sv
module perm_bus_decoder
  import pbd_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter logic [NREG*AW-1:0] REG_BASE = {32'h0000_0000, 32'h0100_0000,
                                            32'h0002_0000, 32'h0000_0100},
  parameter logic [NREG*AW-1:0] REG_MASK = {32'hFFFF_0000, 32'hFF00_0000,
                                            32'hFFFE_0000, 32'hFFFF_FF00},
  parameter logic [NREG*4-1:0]  REG_PERM = {4'b1000, 4'b1011, 4'b1110, 4'b1100}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [1:0]           req_size,
  input  logic [AW-1:0]        req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 err_sample,
  output logic [NREG-1:0]      dev_sel,
  output logic [AW-1:0]        dev_offset,
  output logic                 dev_we,
  output logic [LANES-1:0]     dev_be,
  output logic [DATA_W-1:0]    dev_wdata,
  input  logic [NREG*DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 err_flag
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic            hit;
  logic [NREG-1:0] sel_oh;
  logic [IW-1:0]   sel_idx;

  pbd_region_match #(
    .NREG(NREG), .AW(AW), .REG_BASE(REG_BASE), .REG_MASK(REG_MASK)
  ) u_match (
    .addr   (req_addr),
    .hit    (hit),
    .sel_oh (sel_oh),
    .sel_idx(sel_idx)
  );

  acc_kind_t         kind;
  logic [3:0]        perm;
  logic              need_ok, grant, fault, whole, is_rd, is_wr;
  logic [AW-1:0]     mask_sel, off_raw;
  logic [DATA_W-1:0] rword, rnarrow, wrep;
  logic [LANES-1:0]  be;

  always_comb begin
    kind     = acc_kind_t'(req_kind);
    perm     = REG_PERM[sel_idx*4 +: 4];
    mask_sel = REG_MASK[sel_idx*AW +: AW];
    rword    = dev_rdata[sel_idx*DATA_W +: DATA_W];
    case (kind)
      ACC_LOAD:  need_ok = perm[PB_READ];
      ACC_STORE: need_ok = perm[PB_WRITE];
      ACC_FETCH: need_ok = perm[PB_EXEC];
      default:   need_ok = perm[PB_BULK];
    endcase
    grant = req_valid & hit & need_ok;
    fault = req_valid & ~grant;
    whole = (kind == ACC_FETCH) | (kind == ACC_BULK);
    is_rd = (kind == ACC_LOAD)  | (kind == ACC_FETCH);
    is_wr = (kind == ACC_STORE) | (kind == ACC_BULK);
  end

  pbd_lane_steer u_lanes (
    .size   (req_size),
    .whole  (whole),
    .lo     (req_addr[1:0]),
    .wdata  (req_wdata),
    .rword  (rword),
    .be     (be),
    .wrep   (wrep),
    .rnarrow(rnarrow)
  );

  // offset alignment by access size
  always_comb begin
    off_raw = req_addr & ~mask_sel;
    if (whole || req_size[1])  off_raw[1:0] = 2'b00;
    else if (req_size == 2'd1) off_raw[0]   = 1'b0;
  end

  assign dev_sel    = grant ? sel_oh : '0;
  assign dev_we     = grant & is_wr;
  assign dev_be     = grant ? be : '0;
  assign dev_wdata  = wrep;
  assign dev_offset = off_raw;
  assign rsp_rdata  = (grant & is_rd) ? rnarrow : '0;

  pbd_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_s),
    .fault (fault),
    .sample(err_sample),
    .flag  (err_flag)
  );
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic            req_valid,
  input logic            err_sample,
  input logic [NREG-1:0] dev_sel,
  input logic            dev_we,
  input logic [3:0]      dev_be,
  input logic [31:0]     rsp_rdata,
  input logic            err_flag
);
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(dev_sel));

  p_we_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_q)
    dev_we |-> (dev_sel != '0));

  p_refused_zero_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && dev_sel == '0) |-> (rsp_rdata == 32'd0 && dev_be == 4'd0));

  p_refused_sets_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && dev_sel == '0) |=> err_flag);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (err_flag && !err_sample) |=> err_flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (err_sample && !(req_valid && dev_sel == '0)) |=> !err_flag);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |-> (dev_sel == '0 && !dev_we));
endmodule

bind perm_bus_decoder pbd_checker #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_q     (rst_s),
  .req_valid (req_valid),
  .err_sample(err_sample),
  .dev_sel   (dev_sel),
  .dev_we    (dev_we),
  .dev_be    (dev_be),
  .rsp_rdata (rsp_rdata),
  .err_flag  (err_flag)
);

// File: tb/sim_perm_bus_decoder.sv
`timescale 1ns/1ps
module sim_perm_bus_decoder;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0, req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        err_sample = 1'b0;
  logic [3:0]  dev_sel;
  logic [31:0] dev_offset;
  logic        dev_we;
  logic [3:0]  dev_be;
  logic [31:0] dev_wdata;
  logic [127:0] dev_rdata;
  logic [31:0] rsp_rdata;
  logic        err_flag;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign dev_rdata = {32'hDDEE_FF01, 32'h99AA_BBCC, 32'h5566_7788, 32'h1122_3344};

  perm_bus_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .err_sample(err_sample), .dev_sel(dev_sel), .dev_offset(dev_offset),
    .dev_we(dev_we), .dev_be(dev_be), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .rsp_rdata(rsp_rdata), .err_flag(err_flag)
  );

  // spec-level model of the region table
  logic [31:0] m_base [4] = '{32'h0000_0100, 32'h0002_0000, 32'h0100_0000, 32'h0000_0000};
  logic [31:0] m_mask [4] = '{32'hFFFF_FF00, 32'hFFFE_0000, 32'hFF00_0000, 32'hFFFF_0000};
  logic [3:0]  m_perm [4] = '{4'b1100, 4'b1110, 4'b1011, 4'b1000};
  logic [31:0] m_word [4] = '{32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 32'hDDEE_FF01};
  logic        m_flag = 1'b0;

  typedef struct {
    string       tag;
    logic [3:0]  sel;
    logic [31:0] off;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        err;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic v, input logic [1:0] k,
                       input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] w, input logic smp);
    exp_t e;
    int idx = -1;
    logic ok, whole;
    logic [31:0] word;
    logic [1:0] lo;
    @(posedge clk); #1;
    req_valid = v; req_kind = k; req_size = s; req_addr = a; req_wdata = w; err_sample = smp;
    for (int i = 3; i >= 0; i--) if ((a & m_mask[i]) == m_base[i]) idx = i;
    ok = 1'b0;
    if (v && idx >= 0) ok = m_perm[idx][3 - k];
    whole = (k == 2'd2) || (k == 2'd3);
    lo = a[1:0];
    e.tag = tag; e.err = m_flag;
    e.sel = '0; e.off = '0; e.we = 1'b0; e.be = '0; e.wd = '0; e.rd = '0;
    if (ok) begin
      word  = m_word[idx];
      e.sel = 4'b0001 << idx;
      e.off = a & ~m_mask[idx];
      e.we  = (k == 2'd1) || (k == 2'd3);
      if (whole || s >= 2'd2) begin
        e.off[1:0] = 2'b00; e.be = 4'b1111; e.wd = w;
        e.rd = word;
      end else if (s == 2'd1) begin
        e.off[0] = 1'b0; e.be = lo[1] ? 4'b0011 : 4'b1100;
        e.wd = {w[15:0], w[15:0]};
        e.rd = lo[1] ? {16'd0, word[15:0]} : {16'd0, word[31:16]};
      end else begin
        e.be = 4'b1000 >> lo;
        e.wd = {4{w[7:0]}};
        e.rd = {24'd0, word[31 - 8*lo -: 8]};
      end
      if (e.we) e.rd = '0;
    end
    m_flag = (v && !ok) ? 1'b1 : (smp ? 1'b0 : m_flag);
    sb_q.push_back(e);
  endtask

  // monitor: combinational results are due at the falling edge of the same cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "err_flag", 32'(err_flag), 32'(e.err));
      chk(e.tag, "dev_sel",  32'(dev_sel),  32'(e.sel));
      chk(e.tag, "dev_we",   32'(dev_we),   32'(e.we));
      chk(e.tag, "dev_be",   32'(dev_be),   32'(e.be));
      chk(e.tag, "rsp_rdata", rsp_rdata,    e.rd);
      if (e.sel != '0) chk(e.tag, "dev_offset", dev_offset, e.off);
      if (e.we)        chk(e.tag, "dev_wdata",  dev_wdata,  e.wd);
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R10 reset state, R11 idle
    drive("R10_reset_idle", 0, 2'd1, 2'd2, 32'h0000_0104, 32'hFFFF_FFFF, 0);
    drive("R11_idle_store", 0, 2'd1, 2'd2, 32'h0002_0000, 32'h1234_5678, 0);
    // R1 overlap: region0 beats region3
    drive("R1_priority_load", 1, 2'd0, 2'd2, 32'h0000_0104, 0, 0);
    drive("R1_r3_only_load",  1, 2'd0, 2'd2, 32'h0000_0200, 0, 0);
    // R7 big-endian narrowing
    drive("R7_byte_a1", 1, 2'd0, 2'd0, 32'h0002_0001, 0, 0);
    drive("R7_byte_a3", 1, 2'd0, 2'd0, 32'h0002_0003, 0, 0);
    drive("R7_half_a0", 1, 2'd0, 2'd1, 32'h0002_0000, 0, 0);
    drive("R7_half_a2", 1, 2'd0, 2'd1, 32'h0002_0002, 0, 0);
    // R2 alignment
    drive("R2_half_odd", 1, 2'd0, 2'd1, 32'h0002_0003, 0, 0);
    drive("R2_word_odd", 1, 2'd0, 2'd3, 32'h0002_0007, 0, 0);
    drive("R2_byte_off", 1, 2'd0, 2'd0, 32'h0100_1235, 0, 0);
    // R8 store replication
    drive("R8_store_byte", 1, 2'd1, 2'd0, 32'h0002_0002, 32'h0000_00AB, 0);
    drive("R8_store_half", 1, 2'd1, 2'd1, 32'h0002_0000, 32'h0000_1234, 0);
    drive("R8_store_word", 1, 2'd1, 2'd2, 32'h0000_0108, 32'hCAFE_BABE, 0);
    // R4 write refused, then R9 sticky and clear
    drive("R4_store_rom", 1, 2'd1, 2'd2, 32'h0100_0010, 32'h1111_2222, 0);
    drive("R9_sticky",    0, 2'd0, 2'd0, 32'h0, 0, 0);
    drive("R9_sample",    0, 2'd0, 2'd0, 32'h0, 0, 1);
    drive("R9_cleared",   0, 2'd0, 2'd0, 32'h0, 0, 0);
    // R4 store to read-only region3
    drive("R4_store_r3", 1, 2'd1, 2'd0, 32'h0000_0200, 32'h55, 1);
    // R9 sample with a new fault in the same cycle keeps the flag
    drive("R9_sample_and_fault", 1, 2'd0, 2'd2, 32'h2000_0000, 0, 1);
    drive("R9_flag_kept", 0, 2'd0, 2'd0, 32'h0, 0, 1);
    // R5 fetch
    drive("R5_fetch_ok",   1, 2'd2, 2'd0, 32'h0002_0011, 0, 0);
    drive("R5_fetch_noX",  1, 2'd2, 2'd2, 32'h0000_0108, 0, 0);
    drive("R5_fetch_rom",  1, 2'd2, 2'd1, 32'h0100_0004, 0, 1);
    // R3 unmatched load and read permission
    drive("R3_unmatched", 1, 2'd0, 2'd2, 32'h3000_0000, 0, 1);
    drive("R3_rom_read",  1, 2'd0, 2'd2, 32'h0100_0000, 0, 1);
    // R6 bulk-load
    drive("R6_bulk_rom",  1, 2'd3, 2'd0, 32'h0100_0022, 32'hCAFE_F00D, 0);
    drive("R6_bulk_noL",  1, 2'd3, 2'd2, 32'h0002_0020, 32'h0BAD_0BAD, 0);
    drive("R6_flag_seen", 0, 2'd0, 2'd0, 32'h0, 0, 0);
    // R10 reset clears a set flag
    @(posedge clk); #1;
    rst_n = 1'b0;
    m_flag = 1'b0;
    @(negedge clk);
    chk("R10_async_clear", "err_flag", 32'(err_flag), 32'd0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive("R10_after_reset", 0, 2'd0, 2'd0, 32'h0, 0, 0);
    drive("R11_idle_check",  0, 2'd3, 2'd2, 32'h0100_0000, 32'h1, 0);
    drive("R11_no_err",      0, 2'd0, 2'd0, 32'h0, 0, 0);
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule